// File: doc/BRIEF.md
# Token-Enabled Register FIFO

This block is a synchronous first-in first-out buffer made of a bank of data registers. Once a word is written it never moves. The incoming data bus is wired to every storage cell at once. A rotating one-hot write token picks the single cell that captures on each accepted push. Every other cell keeps its value, so no data travels along a register chain, and the toggling that a shifting buffer causes on every clock is avoided. A second rotating one-hot token marks the oldest word. That token drives an AND-OR multiplexer, which presents the head word at the output. The per-cell write enables mark the points where clock-gating cells would be placed in a low-power flow.

Both data sides use valid/ready handshakes. A word enters on a clock edge where `in_valid` and `in_ready` are both high. A word leaves on an edge where `out_valid` and `out_ready` are both high. `in_ready` depends only on the fill level, never on `out_ready`. A full buffer therefore refuses a push even in the cycle in which it is being drained, and back-pressure never forms a combinational path through the block. The plain status pins give the fill level and the full and empty flags.

Top module: `tok_fifo`

## Requirements
- R1: After a synchronous active-low reset, `count` is 0, `empty` is 1, `full` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: Words leave in the order in which they were accepted.
- R3: An accepted push writes exactly one cell. Words already stored are unchanged and are delivered intact after the write pointer wraps past them.
- R4: The write token advances one cell per accepted push and wraps from cell DEPTH-1 to cell 0, so DEPTH consecutive pushes fill every cell exactly once.
- R5: `count` stays in the range 0 to DEPTH. `full` is high exactly when count equals DEPTH, and `empty` is high exactly when count is 0. `in_ready` is the inverse of `full`, and `out_valid` is the inverse of `empty`.
- R6: A push offered while full is not accepted. Count, stored data and write position are unchanged.
- R7: A pop requested while empty is not accepted. Count stays 0 and the read position is unchanged.
- R8: When a push and a pop are both accepted in the same cycle, count is unchanged and both words are handled in order.
- R9: When the buffer is full and both sides are active, only the pop is accepted and count drops by one.
- R10: While `out_valid` is high, `out_data` equals the oldest stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Buffer can accept a word (not full) |
| in_data | input | WIDTH | Word offered, broadcast to all cells |
| out_valid | output | 1 | Head word is present (not empty) |
| out_ready | input | 1 | Consumer takes the head word |
| out_data | output | WIDTH | Head word selected by the read token |
| full | output | 1 | Fill level equals DEPTH |
| empty | output | 1 | Fill level is zero |
| count | output | $clog2(DEPTH+1) | Number of stored words |

## Verification
A token that is lost, duplicated or stepped at the wrong time shows at `out_data` no later than the next pop that reaches the affected cell. The symptom is a repeated, skipped or stale word against the reference queue. A write enable that reaches the wrong cell overwrites a stored word, and the damage is seen when that word reaches the head, at most DEPTH pops later. A counter error shows at once on `count`, `full`, `empty` and the handshake pins in the cycle after the faulty edge.

// File: rtl/tok_fifo_pkg.sv
package tok_fifo_pkg;
  // Width of an occupancy counter that must hold 0..depth inclusive.
  function automatic int occ_bits(input int depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/ring_token.sv
module ring_token #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [N-1:0] tok
);
  localparam logic [N-1:0] HOME = {{(N-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)    tok <= HOME;
    else if (step) tok <= {tok[N-2:0], tok[N-1]};
  end

  // R4: the token is always a single hot bit
  a_r4_token_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tok) == 1);
  // R4: the token only moves when stepped
  a_r4_token_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(tok));
endmodule

// File: rtl/cell_bank.sv
module cell_bank #(
  parameter int W = 8,
  parameter int N = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        cap_en,
  input  logic [W-1:0]        din,
  output logic [N-1:0][W-1:0] cells
);
  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)         cells[i] <= '0;
      else if (cap_en[i]) cells[i] <= din;
    end

    // R3: a cell without its enable keeps its contents
    a_r3_cell_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en[i] |=> $stable(cells[i]));
  end

  // R3: at most one cell captures per edge
  a_r3_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_en));
endmodule

// File: rtl/onehot_pick.sv
module onehot_pick #(
  parameter int W = 8,
  parameter int N = 8
) (
  input  logic [N-1:0]        sel,
  input  logic [N-1:0][W-1:0] src,
  output logic [W-1:0]        dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      dout = dout | (src[i] & {W{sel[i]}});
    end
  end
endmodule

// File: rtl/occ_counter.sv
module occ_counter #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] level,
  output logic          is_full,
  output logic          is_empty
);
  localparam logic [CW-1:0] TOP = CW'(DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) level <= '0;
    else if (inc && !dec) level <= level + 1'b1;
    else if (dec && !inc) level <= level - 1'b1;
  end

  assign is_full  = (level == TOP);
  assign is_empty = (level == '0);

  // R5: level never exceeds DEPTH
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= TOP);
  // R8: a matched push and pop leave the level unchanged
  a_r8_matched_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(level));
  // R6: no increment is requested at the top
  a_r6_no_inc_full: assert property (@(posedge clk) disable iff (!rst_n)
    is_full |-> !inc);
  // R7: no decrement is requested at zero
  a_r7_no_dec_empty: assert property (@(posedge clk) disable iff (!rst_n)
    is_empty |-> !dec);
endmodule

// File: rtl/tok_fifo.sv
module tok_fifo
  import tok_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int CW   = occ_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count
);
  logic                        push_go, pop_go;
  logic [DEPTH-1:0]            wr_tok, rd_tok, cap_en;
  logic [DEPTH-1:0][WIDTH-1:0] cells;

  assign in_ready  = !full;
  assign out_valid = !empty;
  assign push_go   = in_valid && in_ready;
  assign pop_go    = out_valid && out_ready;
  assign cap_en    = wr_tok & {DEPTH{push_go}};

  ring_token #(.N(DEPTH)) u_wr_tok (
    .clk(clk), .rst_n(rst_n), .step(push_go), .tok(wr_tok));

  ring_token #(.N(DEPTH)) u_rd_tok (
    .clk(clk), .rst_n(rst_n), .step(pop_go), .tok(rd_tok));

  cell_bank #(.W(WIDTH), .N(DEPTH)) u_bank (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .din(in_data), .cells(cells));

  onehot_pick #(.W(WIDTH), .N(DEPTH)) u_pick (
    .sel(rd_tok), .src(cells), .dout(out_data));

  occ_counter #(.DEPTH(DEPTH), .CW(CW)) u_occ (
    .clk(clk), .rst_n(rst_n), .inc(push_go), .dec(pop_go),
    .level(count), .is_full(full), .is_empty(empty));

  // R6: a full buffer keeps its write position unless the level drops
  a_r6_wr_parked: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $stable(wr_tok));
  // R7: an empty buffer keeps its read position
  a_r7_rd_parked: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> $stable(rd_tok));
  // R5: full and empty never coincide
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  // R5: the tokens coincide whenever the buffer is empty or full
  a_r5_tokens_meet: assert property (@(posedge clk) disable iff (!rst_n)
    (full || empty) |-> (wr_tok == rd_tok));
endmodule

// File: tb/tok_fifo_test.sv
module tok_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int D  = 8;
  localparam int CW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_ready, out_valid, out_ready, full, empty;
  logic [W-1:0]  in_data, out_data;
  logic [CW-1:0] count;

  int            n_checks = 0;
  int            n_fails  = 0;
  logic [W-1:0]  mq[$];
  logic [W-1:0]  seq_val = 8'h10;

  always #(CLK_PERIOD/2) clk = ~clk;

  tok_fifo #(.WIDTH(W), .DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .full(full), .empty(empty), .count(count));

  function automatic int exp_count();
    return mq.size();
  endfunction

  function automatic logic exp_full();
    return mq.size() == D;
  endfunction

  function automatic logic exp_empty();
    return mq.size() == 0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: %s got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Drive one cycle, check the state left by the previous edge, advance the model.
  task automatic step(input logic iv, input logic [W-1:0] d, input logic ordy, input string tag);
    logic pu, po;
    @(negedge clk);
    in_valid  = iv;
    in_data   = d;
    out_ready = ordy;
    #1;
    check(tag, "count", int'(count), exp_count());
    check("R5", "full", int'(full), int'(exp_full()));
    check("R5", "empty", int'(empty), int'(exp_empty()));
    check("R5", "in_ready", int'(in_ready), int'(!exp_full()));
    check("R5", "out_valid", int'(out_valid), int'(!exp_empty()));
    if (mq.size() > 0) check(tag, "out_data", int'(out_data), int'(mq[0]));
    pu = iv && (mq.size() < D);
    po = ordy && (mq.size() > 0);
    if (po) void'(mq.pop_front());
    if (pu) mq.push_back(d);
  endtask

  task automatic push_n(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step(1'b1, seq_val, 1'b0, tag);
      seq_val = seq_val + 8'd7;
    end
  endtask

  task automatic pop_n(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b1, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", "count", int'(count), 0);
    check("R1", "empty", int'(empty), 1);
    check("R1", "full", int'(full), 0);
    check("R1", "out_valid", int'(out_valid), 0);
    check("R1", "in_ready", int'(in_ready), 1);

    // R7: pops on an empty buffer are ignored
    pop_n(3, "R7");
    push_n(1, "R7");
    pop_n(2, "R7");

    // R4: DEPTH pushes fill every cell, R2: drain in order
    push_n(D, "R4");
    pop_n(D, "R2");

    // R6: extra pushes while full are refused and leave no trace
    push_n(D, "R6");
    push_n(3, "R6");
    pop_n(D + 1, "R6");

    // R9: full buffer with both sides active
    push_n(D, "R9");
    step(1'b1, 8'hEE, 1'b1, "R9");
    step(1'b1, 8'hDD, 1'b1, "R9");
    pop_n(D + 1, "R9");

    // R8: matched push and pop on a non-empty buffer
    push_n(3, "R8");
    for (int i = 0; i < 10; i++) begin
      step(1'b1, seq_val, 1'b1, "R8");
      seq_val = seq_val + 8'd3;
    end
    pop_n(4, "R8");

    // R3: partial fill, pop, then wrap the write token past stored words
    push_n(5, "R3");
    pop_n(3, "R3");
    push_n(6, "R3");
    pop_n(D + 1, "R3");

    // R10: random traffic with shifting push/pop bias
    for (int blk = 0; blk < 6; blk++) begin
      int pbias = 20 + blk * 12;
      for (int i = 0; i < 500; i++) begin
        logic iv, ordy;
        iv   = (($urandom % 100) < pbias);
        ordy = (($urandom % 100) < (90 - pbias));
        step(iv, W'($urandom), ordy, "R10");
      end
    end
    pop_n(D + 1, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule